// File: doc/BRIEF.md
# Serial Channel Clock Source and Baud Generator

This block makes the bit-rate enables for one serial channel. It runs on the system clock. Two external clock pins are brought into that domain, and each rising edge becomes a one-cycle enable. It also has a programmable baud-rate down-counter and takes a recovered-clock enable from a phase-locked loop outside the block. The transmit path, the receive path and the auxiliary clock output pin each pick their own source from these, independently of one another.

The baud counter counts ticks from either the system clock or external pin A. It is loaded from a 16-bit time constant held in two byte registers. A sampling multiplier then divides the chosen source by 1, 16, 32 or 64 before it reaches the transmit and receive enables. Every time the counter reaches zero it raises a one-cycle status pulse, and an interrupt pulse when that interrupt is enabled.

The surrounding channel holds the configuration bytes and feeds them in as plain inputs. The shift registers consume `tx_clk_en` and `rx_clk_en` as clock enables.

Top module: `serial_clk_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is low.
- R2: The transmit source is set by bits 4:3 of `route_reg`: 00 selects pin A rising edges, 01 pin B rising edges, 10 baud generator rising edges and 11 the `dpll_en` pulses. At x1, each source pulse gives one `tx_clk_en` pulse, one cycle later.
- R3: The receive source is set by bits 6:5 of `route_reg`, with the same encoding as R2, and it is selected independently of the transmit source.
- R4: Bits 1:0 of `route_reg` select what drives `trxc_out`: 00 the synchronised pin A level, 01 the transmit enable, 10 the baud generator output level and 11 `dpll_en`. When bit 2 is clear, `trxc_out` and `trxc_oe` are 0 one cycle later. When bit 2 is set, `trxc_oe` is 1.
- R5: Bit 0 of `gen_ctrl` enables the baud counter. Bit 1 selects the system clock as its tick; when bit 1 is clear, pin A rising edges are its tick. While the counter is disabled it is preset, its output holds, and it gives no zero pulses.
- R6: The time constant is {`tc_hi`,`tc_lo`}. The counter output toggles once every TC+2 input ticks, so its full period is 2*(TC+2) ticks.
- R7: Bits 7:6 of `mode_reg` set the multiplier: 00 x1, 01 x16, 10 x32, 11 x64. Each enable output gives one pulse per N source pulses.
- R8: `brg_zero` pulses for one cycle each time the counter reaches zero. `brg_irq` gives the same pulse only when bit 1 of `irq_ctrl` is set.
- R9: The pins pass through a two-flop synchroniser. A pin rising before clock edge k gives an x1 enable pulse in the cycle after edge k+2. A pin that stays high gives no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | External clock pin A (also the counter's external input) |
| pin_b | input | 1 | External clock pin B |
| dpll_en | input | 1 | Recovered-clock enable pulse from the phase-locked loop |
| route_reg | input | 8 | Clock routing byte: output pin source, output enable, transmit and receive sources |
| gen_ctrl | input | 8 | Baud counter enable and input select |
| tc_lo | input | 8 | Time constant low byte |
| tc_hi | input | 8 | Time constant high byte |
| mode_reg | input | 8 | Multiplier field in bits 7:6 |
| irq_ctrl | input | 8 | Zero-count interrupt enable in bit 1 |
| tx_clk_en | output | 1 | Transmit bit-rate enable |
| rx_clk_en | output | 1 | Receive bit-rate enable |
| trxc_out | output | 1 | Auxiliary clock output value |
| trxc_oe | output | 1 | Auxiliary clock output drive enable |
| brg_zero | output | 1 | Zero-count status pulse |
| brg_irq | output | 1 | Zero-count interrupt pulse |

## Verification
The bench drives the routing through every source code on transmit and receive. Each pair is set so that the two paths differ, which catches swapped or shared select fields. Gaps between enable pulses are measured with the baud counter fed by the system clock at TC=3 and TC=0x0102. Using a high byte above zero shows whether both bytes reach the counter and whether the divide is 2*(TC+2) rather than 2*(TC+1). Feeding the counter from pin A instead separates the two input choices. The x16, x32 and x64 settings each give a distinct gap, and a single held pin edge checks both the synchroniser latency and that a level is not treated as a stream of edges.

// File: rtl/scg_pkg.sv
package scg_pkg;

    localparam int BYTE_W   = 8;
    localparam int RATIO_W  = 7;

    localparam int GEN_EN_BIT    = 0;
    localparam int GEN_SYSCK_BIT = 1;
    localparam int IRQ_ZERO_BIT  = 1;
    localparam int MODE_MUL_LSB  = 6;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'b00,
        SRC_PIN_B = 2'b01,
        SRC_BAUD  = 2'b10,
        SRC_DPLL  = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        OUT_PIN_A = 2'b00,
        OUT_TXCLK = 2'b01,
        OUT_BAUD  = 2'b10,
        OUT_DPLL  = 2'b11
    } pin_sel_e;

    typedef enum logic [1:0] {
        MUL_X1  = 2'b00,
        MUL_X16 = 2'b01,
        MUL_X32 = 2'b10,
        MUL_X64 = 2'b11
    } mul_e;

    typedef struct packed {
        logic     spare;
        src_sel_e rx_src;
        src_sel_e tx_src;
        logic     pin_oe;
        pin_sel_e pin_src;
    } route_t;

    typedef struct packed {
        logic a_rise;
        logic b_rise;
        logic baud_tick;
        logic dpll_tick;
    } src_vec_t;

    function automatic logic pick_src(input src_sel_e sel, input src_vec_t v);
        case (sel)
            SRC_PIN_A: return v.a_rise;
            SRC_PIN_B: return v.b_rise;
            SRC_BAUD:  return v.baud_tick;
            default:   return v.dpll_tick;
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] mul_ratio(input mul_e m);
        case (m)
            MUL_X1:  return RATIO_W'(1);
            MUL_X16: return RATIO_W'(16);
            MUL_X32: return RATIO_W'(32);
            default: return RATIO_W'(64);
        endcase
    endfunction

endpackage

// File: rtl/scg_edge_sync.sv
module scg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sh_q[STAGES-1];
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~prev_q;

    // R9: a level held high yields one edge only
    p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/scg_baud_counter.sv
module scg_baud_counter #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            in_tick,
    input  logic [TC_W-1:0] tc,
    input  logic            zero_ie,
    output logic            baud_lvl,
    output logic            baud_tick,
    output logic            zero_pulse,
    output logic            irq_pulse
);
    localparam int CNT_W = TC_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;
    logic             hit;

    assign reload = {1'b0, tc} + 1'b1;
    assign hit    = enable & in_tick & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            baud_lvl <= 1'b0;
        end else if (!enable) begin
            cnt_q    <= reload;
        end else if (in_tick) begin
            if (cnt_q == '0) begin
                cnt_q    <= reload;
                baud_lvl <= ~baud_lvl;
            end else begin
                cnt_q    <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_pulse <= 1'b0;
            irq_pulse  <= 1'b0;
            baud_tick  <= 1'b0;
        end else begin
            zero_pulse <= hit;
            irq_pulse  <= hit & zero_ie;
            baud_tick  <= hit & ~baud_lvl;
        end
    end

    // R5: disabled counter never reports zero
    p_idle_no_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !zero_pulse);
    // R6: every zero event flips the output
    p_zero_toggles_r6: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |-> (baud_lvl != $past(baud_lvl)));
    // R6: tick marks a low-to-high output change
    p_tick_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> (baud_lvl && !$past(baud_lvl)));
    // R8: interrupt only alongside a zero pulse
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> zero_pulse);
endmodule

// File: rtl/scg_prescaler.sv
module scg_prescaler #(
    parameter int RATIO_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src,
    input  logic [RATIO_W-1:0] ratio,
    output logic               pulse
);
    logic [RATIO_W-1:0] cnt_q;
    logic               last;

    assign last = (cnt_q >= ratio - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= src & last;
            if (src) cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    // R7: an enable pulse is always caused by a source pulse
    p_pulse_from_src_r7: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(src));
endmodule

// File: rtl/serial_clk_gen.sv
module serial_clk_gen
    import scg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TC_BYTES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              dpll_en,
    input  logic [BYTE_W-1:0] route_reg,
    input  logic [BYTE_W-1:0] gen_ctrl,
    input  logic [BYTE_W-1:0] tc_lo,
    input  logic [BYTE_W-1:0] tc_hi,
    input  logic [BYTE_W-1:0] mode_reg,
    input  logic [BYTE_W-1:0] irq_ctrl,
    output logic              tx_clk_en,
    output logic              rx_clk_en,
    output logic              trxc_out,
    output logic              trxc_oe,
    output logic              brg_zero,
    output logic              brg_irq
);
    localparam int TC_W   = TC_BYTES * BYTE_W;
    localparam int N_PINS = 2;
    localparam int N_CH   = 2;

    route_t             route;
    mul_e               mul;
    logic [RATIO_W-1:0] ratio;
    logic [N_PINS-1:0]  pin_vec, pin_lvl, pin_rise;
    logic               baud_lvl, baud_tick, cnt_tick;
    src_vec_t           srcs;
    src_sel_e           ch_sel [N_CH];
    logic [N_CH-1:0]    ch_src, ch_en;
    logic               pin_nxt;
    logic               unused_bits;

    assign route   = route_t'(route_reg);
    assign mul     = mul_e'(mode_reg[MODE_MUL_LSB +: 2]);
    assign ratio   = mul_ratio(mul);
    assign pin_vec = {pin_b, pin_a};

    assign unused_bits = ^{route.spare, gen_ctrl[BYTE_W-1:2],
                           mode_reg[MODE_MUL_LSB-1:0], irq_ctrl[BYTE_W-1:2], irq_ctrl[0]};

    generate
        for (genvar p = 0; p < N_PINS; p++) begin : g_pin
            scg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst   (rst),
                .pin   (pin_vec[p]),
                .level (pin_lvl[p]),
                .rise  (pin_rise[p])
            );
        end
    endgenerate

    assign cnt_tick = gen_ctrl[GEN_SYSCK_BIT] ? 1'b1 : pin_rise[0];

    scg_baud_counter #(.TC_W(TC_W)) u_baud (
        .clk        (clk),
        .rst        (rst),
        .enable     (gen_ctrl[GEN_EN_BIT]),
        .in_tick    (cnt_tick),
        .tc         ({tc_hi, tc_lo}),
        .zero_ie    (irq_ctrl[IRQ_ZERO_BIT]),
        .baud_lvl   (baud_lvl),
        .baud_tick  (baud_tick),
        .zero_pulse (brg_zero),
        .irq_pulse  (brg_irq)
    );

    assign srcs.a_rise    = pin_rise[0];
    assign srcs.b_rise    = pin_rise[1];
    assign srcs.baud_tick = baud_tick;
    assign srcs.dpll_tick = dpll_en;

    assign ch_sel[0] = route.tx_src;
    assign ch_sel[1] = route.rx_src;

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            assign ch_src[c] = pick_src(ch_sel[c], srcs);
            scg_prescaler #(.RATIO_W(RATIO_W)) u_pre (
                .clk   (clk),
                .rst   (rst),
                .src   (ch_src[c]),
                .ratio (ratio),
                .pulse (ch_en[c])
            );
        end
    endgenerate

    assign tx_clk_en = ch_en[0];
    assign rx_clk_en = ch_en[1];

    always_comb begin
        case (route.pin_src)
            OUT_PIN_A: pin_nxt = pin_lvl[0];
            OUT_TXCLK: pin_nxt = ch_en[0];
            OUT_BAUD:  pin_nxt = baud_lvl;
            default:   pin_nxt = dpll_en;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trxc_out <= 1'b0;
            trxc_oe  <= 1'b0;
        end else begin
            trxc_out <= route.pin_oe & pin_nxt;
            trxc_oe  <= route.pin_oe;
        end
    end

    // R4: output pin silent when its drive bit is clear
    p_pin_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !route.pin_oe |=> (!trxc_out && !trxc_oe));
    // R2: at x1 a selected DPLL pulse reaches the transmit enable
    p_tx_dpll_r2: assert property (@(posedge clk) disable iff (rst)
        (route.tx_src == SRC_DPLL && mul == MUL_X1 && dpll_en) |=> tx_clk_en);
endmodule

// File: tb/test_serial_clk_gen.sv
module test_serial_clk_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_a = 0, pin_b = 0, dpll_en = 0;
    logic [7:0] route_reg = 0, gen_ctrl = 0, tc_lo = 0, tc_hi = 0, mode_reg = 0, irq_ctrl = 0;
    logic tx_clk_en, rx_clk_en, trxc_out, trxc_oe, brg_zero, brg_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    serial_clk_gen i_serial_clk_gen (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .dpll_en(dpll_en),
        .route_reg(route_reg), .gen_ctrl(gen_ctrl), .tc_lo(tc_lo), .tc_hi(tc_hi),
        .mode_reg(mode_reg), .irq_ctrl(irq_ctrl),
        .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en), .trxc_out(trxc_out),
        .trxc_oe(trxc_oe), .brg_zero(brg_zero), .brg_irq(brg_irq));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference, one step per clock ----------------
    int m_a1, m_a2, m_a3, m_b1, m_b2, m_b3;
    int m_cnt, m_bo, m_tick, m_zero, m_irq;
    int m_ptx, m_prx, m_tx, m_rx, m_pin, m_oe;

    function automatic int pick(input int sel, input int a, input int b, input int c, input int d);
        return (sel == 0) ? a : (sel == 1) ? b : (sel == 2) ? c : d;
    endfunction

    always @(posedge clk) begin
        int ra, rb, tin, zh, stx, srx, n, tcv, ntx, nrx;
        if (rst) begin
            m_a1 = 0; m_a2 = 0; m_a3 = 0; m_b1 = 0; m_b2 = 0; m_b3 = 0;
            m_cnt = 0; m_bo = 0; m_tick = 0; m_zero = 0; m_irq = 0;
            m_ptx = 0; m_prx = 0; m_tx = 0; m_rx = 0; m_pin = 0; m_oe = 0;
        end else begin
            ra  = m_a2 & ~m_a3 & 1;
            rb  = m_b2 & ~m_b3 & 1;
            tin = gen_ctrl[1] ? 1 : ra;
            tcv = tc_hi * 256 + tc_lo;
            zh  = (gen_ctrl[0] && tin && m_cnt == 0) ? 1 : 0;
            stx = pick(route_reg[4:3], ra, rb, m_tick, dpll_en);
            srx = pick(route_reg[6:5], ra, rb, m_tick, dpll_en);
            n   = pick(mode_reg[7:6], 1, 16, 32, 64);
            ntx = (stx && m_ptx >= n - 1) ? 1 : 0;
            nrx = (srx && m_prx >= n - 1) ? 1 : 0;
            if (stx) m_ptx = (m_ptx >= n - 1) ? 0 : m_ptx + 1;
            if (srx) m_prx = (m_prx >= n - 1) ? 0 : m_prx + 1;
            m_pin = route_reg[2] ? pick(route_reg[1:0], m_a2, m_tx, m_bo, dpll_en) : 0;
            m_oe  = route_reg[2];
            m_tick = (zh && !m_bo) ? 1 : 0;
            m_zero = zh;
            m_irq  = (zh && irq_ctrl[1]) ? 1 : 0;
            if (!gen_ctrl[0]) m_cnt = tcv + 1;
            else if (tin) begin
                if (m_cnt == 0) begin m_cnt = tcv + 1; m_bo = 1 - m_bo; end
                else m_cnt = m_cnt - 1;
            end
            m_tx = ntx; m_rx = nrx;
            m_a3 = m_a2; m_a2 = m_a1; m_a1 = pin_a;
            m_b3 = m_b2; m_b2 = m_b1; m_b1 = pin_b;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            check(tx_clk_en == m_tx[0], "R2 tx_clk_en model", tx_clk_en, m_tx);
            check(rx_clk_en == m_rx[0], "R3 rx_clk_en model", rx_clk_en, m_rx);
            check(trxc_out == m_pin[0], "R4 trxc_out model", trxc_out, m_pin);
            check(trxc_oe == m_oe[0], "R4 trxc_oe model", trxc_oe, m_oe);
            check(brg_zero == m_zero[0], "R8 brg_zero model", brg_zero, m_zero);
            check(brg_irq == m_irq[0], "R8 brg_irq model", brg_irq, m_irq);
        end
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic cfg(input logic [7:0] rt, input logic [7:0] gc, input logic [7:0] lo,
                       input logic [7:0] hi, input logic [7:0] md, input logic [7:0] ic);
        @(negedge clk);
        route_reg = rt; gen_ctrl = gc; tc_lo = lo; tc_hi = hi; mode_reg = md; irq_ctrl = ic;
    endtask

    function automatic logic sig(input int w);
        case (w)
            0: return tx_clk_en;
            1: return rx_clk_en;
            2: return trxc_out;
            3: return brg_zero;
            default: return brg_irq;
        endcase
    endfunction

    task automatic count_sig(input int w, input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sig(w)) cnt++;
        end
    endtask

    task automatic gap_tx(input int exp, input string req);
        int n = 0;
        for (int k = 0; k < 2; k++) begin
            do begin @(negedge clk); n++; end while (!tx_clk_en && n < 5000);
        end
        n = 0;
        do begin @(negedge clk); n++; end while (!tx_clk_en && n < 5000);
        check(n == exp, req, n, exp);
    endtask

    initial begin
        int c;
        repeat (4) @(negedge clk);
        // R1: outputs low during reset
        check({tx_clk_en, rx_clk_en, trxc_out, trxc_oe, brg_zero, brg_irq} == 0, "R1 reset", 1, 0);
        rst = 0;
        @(negedge clk);
        check({tx_clk_en, rx_clk_en, trxc_out, trxc_oe, brg_zero, brg_irq} == 0, "R1 after reset", 1, 0);

        // R9 / R2: tx from pin A, rx from pin B; single held edge, latency 3 edges
        cfg(8'b0_01_00_000, 8'h00, 0, 0, 8'h00, 8'h00);
        repeat (4) @(negedge clk);
        pin_a = 1;
        @(negedge clk); check(tx_clk_en == 0, "R9 latency edge1", tx_clk_en, 0);
        @(negedge clk); check(tx_clk_en == 0, "R9 latency edge2", tx_clk_en, 0);
        @(negedge clk); check(tx_clk_en == 1, "R9 latency edge3", tx_clk_en, 1);
        check(rx_clk_en == 0, "R3 rx ignores pin A", rx_clk_en, 0);
        count_sig(0, 20, c);
        check(c == 0, "R9 held pin no repeat", c, 0);
        pin_a = 0;
        // pin B pulses only reach rx
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) pin_b = 1;
            repeat (3) @(negedge clk);
            pin_b = 0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        // R3: swap - tx from pin B, rx from pin A, toggle both
        cfg(8'b0_00_01_000, 8'h00, 0, 0, 8'h00, 8'h00);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); pin_a = ~pin_a; pin_b = (i % 2 == 0) ? ~pin_b : pin_b;
            repeat (3) @(negedge clk);
        end

        // R6 / R5: counter on system clock, TC=3 -> tx pulse every 10 cycles
        cfg(8'b0_10_10_110, 8'h03, 8'h03, 8'h00, 8'h00, 8'h00);
        gap_tx(10, "R6 TC=3 period");
        // R4: output pin shows counter level, high half the time
        count_sig(2, 100, c);
        check(c == 50, "R4 pin baud level duty", c, 50);
        // R8: zero every 5 cycles, irq masked
        count_sig(3, 50, c);
        check(c == 10, "R8 zero pulses", c, 10);
        count_sig(4, 50, c);
        check(c == 0, "R8 irq masked", c, 0);
        cfg(8'b0_10_10_110, 8'h03, 8'h03, 8'h00, 8'h00, 8'h02);
        @(negedge clk);
        count_sig(4, 50, c);
        check(c == 10, "R8 irq enabled", c, 10);

        // R6: high byte used, TC=0x0102 -> 520
        cfg(8'b0_10_10_110, 8'h03, 8'h02, 8'h01, 8'h00, 8'h00);
        gap_tx(520, "R6 TC=0x0102 period");

        // R5: disabled counter gives nothing
        cfg(8'b0_10_10_010, 8'h02, 8'h00, 8'h00, 8'h00, 8'h02);
        @(negedge clk);
        count_sig(3, 100, c);
        check(c == 0, "R5 disabled no zero", c, 0);
        // R4: drive bit clear
        check(trxc_out == 0 && trxc_oe == 0, "R4 pin quiet", trxc_out, 0);

        // R5: counter fed from pin A, TC=0, pin rising every 8 cycles -> 32
        cfg(8'b0_10_10_110, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
        fork
            begin : g_tog
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk); pin_a = ~pin_a;
                    repeat (3) @(negedge clk);
                end
            end
            gap_tx(32, "R5 pin A as counter input");
        join
        pin_a = 0;

        // R7: multipliers on a 4-cycle baud tick
        cfg(8'b0_10_10_001, 8'h03, 8'h00, 8'h00, 8'h40, 8'h00);
        gap_tx(64, "R7 x16");
        cfg(8'b0_10_10_001, 8'h03, 8'h00, 8'h00, 8'h80, 8'h00);
        gap_tx(128, "R7 x32");
        cfg(8'b0_10_10_001, 8'h03, 8'h00, 8'h00, 8'hC0, 8'h00);
        gap_tx(256, "R7 x64");

        // R2: DPLL source on tx, pin B on rx; pin shows DPLL
        cfg(8'b0_01_11_111, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        dpll_en = 1;
        @(negedge clk);
        dpll_en = 0;
        check(tx_clk_en == 1, "R2 dpll to tx", tx_clk_en, 1);
        check(rx_clk_en == 0, "R3 rx not dpll", rx_clk_en, 0);
        check(trxc_out == 1, "R4 pin shows dpll", trxc_out, 1);
        @(negedge clk);
        check(tx_clk_en == 0, "R2 dpll single pulse", tx_clk_en, 0);
        repeat (5) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule